// File: doc/BRIEF.md
# Minimum-Cost Disparity Selector

This block sits at the end of a window-matching stereo pipeline. Each valid cycle it receives one cost per candidate shift, 64 costs of 15 bits, all presented together on one flat bus. Cost number k sits in bits [15k+14:15k]. The block finds the candidate with the smallest cost and returns that candidate's number as an 8-bit disparity. The disparity appears one clock later, together with a valid flag.

The search is a balanced tree of 63 two-input compare-and-select cells. Two half trees of 31 cells each handle candidates 0..31 and 32..63. One last cell picks between the two half winners. Every cell carries the candidate number along with the cost, so the winning number comes out of the root with no second pass. The whole tree is combinational and resolves in one clock period. A single output register follows it. The block has no state machine. Its only state is that output register and the valid flag.

Top module: `mincost_sel`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `disp_vld_o` is 0 and `disp_o` is 0.
- R2: One cycle after a cycle with `vld_i` high, `disp_o` equals the number k (0..63) of the smallest cost among the 64 fields `cost_i[15k+14:15k]` sampled in that cycle.
- R3: When several fields share the smallest cost, `disp_o` gives the lowest of their numbers. This applies inside one half tree and across the two halves.
- R4: `disp_vld_o` equals `vld_i` delayed by exactly one clock.
- R5: In a cycle with `vld_i` low, `cost_i` has no effect and `disp_o` keeps its previous value.
- R6: The disparity is 8 bits wide and bits 7:6 are always 0.
- R7: At the ends of the cost range the result is still correct. When every cost is 32767 the result is 0. A single 0 at field 63 among 32767s gives 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Cost vector valid |
| cost_i | input | 960 | 64 packed costs; field k occupies bits [15k+14:15k] |
| disp_o | output | 8 | Registered index of the minimum cost |
| disp_vld_o | output | 1 | Registered valid, one cycle after `vld_i` |

## Verification
The only state in this block is the output register pair, and it is rewritten on every valid cycle. A fault in the tree shows on `disp_o` in the cycle right after the faulty cost vector is presented. Typical faults are a swapped compare, a lost index offset in the upper half, or a flipped tie rule. A fault in the hold or valid path shows within one cycle of a `vld_i` change. For these reasons the bench compares against a reference model on every cycle. It also uses narrow-range random costs so that ties across the two halves occur often.

// File: rtl/mincost_pkg.sv
package mincost_pkg;
    localparam int unsigned NUM_COSTS_DEF = 64;
    localparam int unsigned COST_W_DEF    = 15;
    localparam int unsigned DISP_W_DEF    = 8;
endpackage

// File: rtl/mincost_cmp.sv
module mincost_cmp #(
    parameter int unsigned COST_W = 15,
    parameter int unsigned IDX_W  = 6
) (
    input  logic [COST_W-1:0] lo_cost,
    input  logic [IDX_W-1:0]  lo_idx,
    input  logic [COST_W-1:0] hi_cost,
    input  logic [IDX_W-1:0]  hi_idx,
    output logic [COST_W-1:0] win_cost,
    output logic [IDX_W-1:0]  win_idx
);
    // Select bit: the upper-index side wins only when strictly cheaper.
    logic take_hi;
    assign take_hi  = (hi_cost < lo_cost);
    assign win_cost = take_hi ? hi_cost : lo_cost;
    assign win_idx  = take_hi ? hi_idx  : lo_idx;

    always_comb begin
        p_win_not_larger_r2: assert (win_cost <= lo_cost && win_cost <= hi_cost);
        if (lo_cost == hi_cost) begin
            p_tie_lower_r3: assert (win_idx == lo_idx);
        end
    end
endmodule

// File: rtl/mincost_half.sv
module mincost_half #(
    parameter int unsigned N_LEAF = 32,
    parameter int unsigned COST_W = 15,
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned BASE   = 0
) (
    input  logic [N_LEAF*COST_W-1:0] cost_i,
    output logic [COST_W-1:0]        win_cost,
    output logic [IDX_W-1:0]         win_idx
);
    localparam int unsigned NODES = 2 * N_LEAF;

    // Heap layout: node k merges nodes 2k and 2k+1; leaves at N_LEAF..NODES-1.
    logic [COST_W-1:0] c_n [1:NODES-1];
    logic [IDX_W-1:0]  i_n [1:NODES-1];

    for (genvar g = 0; g < N_LEAF; g++) begin : g_leaf
        assign c_n[N_LEAF+g] = cost_i[g*COST_W +: COST_W];
        assign i_n[N_LEAF+g] = IDX_W'(BASE + g);
    end

    for (genvar k = 1; k < N_LEAF; k++) begin : g_node
        mincost_cmp #(.COST_W(COST_W), .IDX_W(IDX_W)) u_cmp (
            .lo_cost  (c_n[2*k]),
            .lo_idx   (i_n[2*k]),
            .hi_cost  (c_n[2*k+1]),
            .hi_idx   (i_n[2*k+1]),
            .win_cost (c_n[k]),
            .win_idx  (i_n[k])
        );
    end

    assign win_cost = c_n[1];
    assign win_idx  = i_n[1];
endmodule

// File: rtl/mincost_sel.sv
module mincost_sel
    import mincost_pkg::*;
#(
    parameter int unsigned NUM_COSTS = NUM_COSTS_DEF,
    parameter int unsigned COST_W    = COST_W_DEF,
    parameter int unsigned DISP_W    = DISP_W_DEF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        vld_i,
    input  logic [NUM_COSTS*COST_W-1:0] cost_i,
    output logic [DISP_W-1:0]           disp_o,
    output logic                        disp_vld_o
);
    localparam int unsigned HALF  = NUM_COSTS / 2;
    localparam int unsigned IDX_W = $clog2(NUM_COSTS);
    localparam int unsigned HW    = HALF * COST_W;

    logic [COST_W-1:0] lo_cost, hi_cost, fin_cost;
    logic [IDX_W-1:0]  lo_idx,  hi_idx,  fin_idx;

    mincost_half #(.N_LEAF(HALF), .COST_W(COST_W), .IDX_W(IDX_W), .BASE(0)) u_half_lo (
        .cost_i   (cost_i[HW-1:0]),
        .win_cost (lo_cost),
        .win_idx  (lo_idx)
    );

    mincost_half #(.N_LEAF(HALF), .COST_W(COST_W), .IDX_W(IDX_W), .BASE(HALF)) u_half_hi (
        .cost_i   (cost_i[2*HW-1:HW]),
        .win_cost (hi_cost),
        .win_idx  (hi_idx)
    );

    mincost_cmp #(.COST_W(COST_W), .IDX_W(IDX_W)) u_root (
        .lo_cost  (lo_cost),
        .lo_idx   (lo_idx),
        .hi_cost  (hi_cost),
        .hi_idx   (hi_idx),
        .win_cost (fin_cost),
        .win_idx  (fin_idx)
    );

    // Output register: loads only on a valid cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_o     <= '0;
            disp_vld_o <= 1'b0;
        end else begin
            disp_vld_o <= vld_i;
            if (vld_i) begin
                disp_o <= DISP_W'(fin_idx);
            end
        end
    end

    always_comb begin
        p_half_index_range_r3: assert (lo_idx < IDX_W'(HALF) && hi_idx >= IDX_W'(HALF));
        p_root_min_r2: assert (fin_cost <= lo_cost && fin_cost <= hi_cost);
    end

    p_vld_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (disp_vld_o == $past(vld_i)));

    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(vld_i)) |-> $stable(disp_o));

    p_disp_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_o < DISP_W'(NUM_COSTS));
endmodule

// File: tb/mincost_sel_tb.sv
module mincost_sel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 64;
    localparam int CW = 15;
    localparam int WATCHDOG = 5000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            vld_i = 1'b0;
    logic [N*CW-1:0] cost_i = '0;
    logic [7:0]      disp_o;
    logic            disp_vld_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_tag = "R2";

    int    exp_disp = 0;
    bit    exp_vld  = 1'b0;
    string exp_tag  = "R1";
    bit    done     = 1'b0;

    mincost_sel u_dut (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .cost_i(cost_i),
        .disp_o(disp_o), .disp_vld_o(disp_vld_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: argmin with lowest-index tie rule, registered on valid.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_disp = 0;
            exp_vld  = 1'b0;
            exp_tag  = "R1";
        end else begin
            exp_vld = vld_i;
            if (vld_i) begin
                int best;
                best = 0;
                for (int k = 1; k < N; k++) begin
                    if (cost_i[k*CW +: CW] < cost_i[best*CW +: CW]) best = k;
                end
                exp_disp = best;
                exp_tag  = cur_tag;
            end else begin
                exp_tag = "R5";
            end
        end
    end

    task automatic report_end();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycles=%0d expected <= %0d", cycles, WATCHDOG);
            report_end();
        end
        if (!rst_n) begin
            checks++;
            if (disp_vld_o !== 1'b0 || disp_o !== 8'd0) begin
                errors++;
                $display("FAIL R1 reset: actual vld=%0b disp=%0d expected vld=0 disp=0",
                         disp_vld_o, disp_o);
            end
        end else begin
            checks++;
            if (disp_vld_o !== exp_vld) begin
                errors++;
                $display("FAIL R4 valid delay: actual %0b expected %0b", disp_vld_o, exp_vld);
            end
            checks++;
            if (disp_o !== 8'(exp_disp)) begin
                errors++;
                $display("FAIL %s disparity: actual %0d expected %0d", exp_tag, disp_o, exp_disp);
            end
            checks++;
            if (disp_o[7:6] !== 2'b00) begin
                errors++;
                $display("FAIL R6 upper bits: actual %0b expected 00", disp_o[7:6]);
            end
        end
    end

    task automatic fill(input int val);
        for (int k = 0; k < N; k++) cost_i[k*CW +: CW] = CW'(val);
    endtask

    task automatic put(input int k, input int val);
        cost_i[k*CW +: CW] = CW'(val);
    endtask

    task automatic apply(input bit v, input string tag);
        vld_i   = v;
        cur_tag = tag;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R7: all at maximum gives index 0
        fill(32767); apply(1'b1, "R7");
        // R7: single zero at the top index
        fill(32767); put(63, 0); apply(1'b1, "R7");
        // R2: descending costs, minimum at 63
        for (int k = 0; k < N; k++) put(k, 1000 - k);
        apply(1'b1, "R2");
        // R2: minimum exactly at the first upper-half index
        fill(500); put(32, 3); apply(1'b1, "R2");
        // R2: minimum at 0
        fill(500); put(0, 1); apply(1'b1, "R2");
        // R3: all equal gives 0
        fill(77); apply(1'b1, "R3");
        // R3: tie across halves, 10 and 40
        fill(900); put(10, 5); put(40, 5); apply(1'b1, "R3");
        // R3: tie at the half boundary, 31 and 32
        fill(900); put(32, 5); put(31, 5); apply(1'b1, "R3");
        // R3: tie inside upper half, 50 and 45
        fill(900); put(50, 2); put(45, 2); apply(1'b1, "R3");
        // R5: new costs while idle must not change the output
        fill(900); put(20, 0); apply(1'b0, "R5");
        fill(900); put(60, 0); apply(1'b0, "R5");
        apply(1'b1, "R2");
        // Random: wide range (R2) and narrow range to force ties (R3)
        for (int t = 0; t < 400; t++) begin
            bit narrow;
            narrow = (t % 2) == 1;
            for (int k = 0; k < N; k++)
                put(k, narrow ? int'($urandom_range(0, 3)) : int'($urandom_range(0, 32767)));
            apply(($urandom_range(0, 3) != 0), narrow ? "R3" : "R2");
        end
        apply(1'b0, "R5");
        apply(1'b0, "R5");
        @(negedge clk);
        #1;
        done = 1'b1;
        report_end();
    end
endmodule